// File: doc/BRIEF.md
# Rotating Priority Interrupt Arbiter

An eight-line interrupt controller core. It holds three state vectors: requests, masks and lines in service. Each line is set to edge or level capture by its own mode bit. A resolver measures priority from a rotating base. The interrupt output is raised only when the best unmasked request strictly outranks the best line in service.

The processor side has an acknowledge strobe, which returns the winning line and moves it into service. It also has a command strobe that carries a 3-bit opcode and a 3-bit line field. The commands end service, rotate the base and set the rotate-on-auto-end option. Special-mask mode and the cascade-input exclusion change only the in-service side of the comparison.

Top module: `rpia_core`

## Requirements
- R1: Slot k maps to line (k + base) mod 8, and slot 0 ranks highest. `ack_line_o` gives the line in the best pending slot while `int_o` is high, and 7 otherwise. With base 0, the lower line number wins.
- R2: Pending priority is taken over requests AND NOT mask, and current priority over the in-service bits. `int_o` is 1 only when the pending slot is strictly lower than the current slot. An empty vector ranks as slot 8.
- R3: When `special_mask_i` is 1, masked in-service bits are dropped before current priority is computed.
- R4: When `nested_i` is 1, in-service bit 2 (the cascade input) is dropped before current priority is computed.
- R5: A line with `level_i` bit = 0 sets its request bit only on a 0-to-1 change of `irq_i`, and a held-high input sets it no second time. A line with `level_i` bit = 1 has its request bit equal to the input one clock later.
- R6: `ack_i` while `int_o` = 1 sets the winning line's in-service bit (auto-end off) and clears its request bit only if the line is edge-mode. `ack_i` while `int_o` = 0 changes no state.
- R7: With `auto_eoi_i` = 1, acknowledge sets no in-service bit. If rotate-on-auto-end is also set, the base becomes line+1.
- R8: Opcode 1 clears the highest-priority in-service bit. Opcode 5 does the same and also sets the base to that line+1. With nothing in service, neither opcode changes the in-service bits or the base.
- R9: Opcode 3 clears the in-service bit of `cmd_line_i`. Opcode 6 sets the base to `cmd_line_i`+1. Opcode 7 does both.
- R10: Opcode 4 sets rotate-on-auto-end and opcode 0 clears it. Opcode 2 changes nothing.
- R11: When `ack_i` and `cmd_valid_i` are high in the same cycle, the command is dropped.
- R12: Reset clears the requests, masks, in-service bits, base and rotate-on-auto-end, so `int_o` reads 0. `mask_we_i` loads `mask_i` into the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| irq_i | input | 8 | interrupt inputs |
| level_i | input | 8 | per-line capture mode, 1 = level |
| mask_we_i | input | 1 | mask register load strobe |
| mask_i | input | 8 | mask value to load |
| auto_eoi_i | input | 1 | automatic end of service on acknowledge |
| special_mask_i | input | 1 | exclude masked lines from the in-service comparison |
| nested_i | input | 1 | exclude cascade line 2 from the in-service comparison |
| cmd_valid_i | input | 1 | command strobe |
| cmd_op_i | input | 3 | command opcode |
| cmd_line_i | input | 3 | command line field |
| ack_i | input | 1 | interrupt acknowledge strobe |
| int_o | output | 1 | interrupt request to processor |
| ack_line_o | output | 3 | winning line, 7 when none |
| irr_o | output | 8 | request register |
| isr_o | output | 8 | in-service register |
| base_o | output | 3 | current priority base |

## Verification
The resolver is driven through a table of level-mode request and mask patterns with nothing in service. These patterns tell a lowest-line winner apart from a masked-out winner, from a top-line winner and from a fully masked set. Directed sequences then put lines in service to separate three cases of pending against current priority: lower, equal and higher. They also toggle special-mask and cascade exclusion to show a suppressed request released. Edge inputs are held high across acknowledges, which tells edge capture apart from level following. Every opcode, the auto-end variants and the ack-over-command collision are each observed through the in-service and base outputs.

// File: rtl/rpia_pkg.sv
package rpia_pkg;
  localparam int unsigned N_LINES = 8;
  localparam int unsigned LINE_W  = $clog2(N_LINES);

  typedef enum logic [2:0] {
    OP_ROT_AEOI_CLR = 3'd0,
    OP_NS_EOI       = 3'd1,
    OP_NOP          = 3'd2,
    OP_SP_EOI       = 3'd3,
    OP_ROT_AEOI_SET = 3'd4,
    OP_NS_EOI_ROT   = 3'd5,
    OP_SET_BASE     = 3'd6,
    OP_SP_EOI_ROT   = 3'd7
  } rpia_op_e;
endpackage

// File: rtl/rpia_prio.sv
// Rotating priority encoder: slot of the first set bit counted from base_i.
module rpia_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] base_i,
  output logic [W:0]   slot_o,
  output logic [W-1:0] line_o
);
  always_comb begin
    int idx;
    slot_o = (W+1)'(N);
    line_o = '0;
    idx    = 0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = (k + int'(base_i)) % N;
      if (vec_i[idx]) begin
        slot_o = (W+1)'(k);
        line_o = W'(idx);
      end
    end
  end
endmodule

// File: rtl/rpia_req.sv
module rpia_req #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] irq_q, irr_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic nxt;
    always_comb begin
      if (level_i[i]) nxt = irq_i[i];
      else            nxt = (irr_q[i] & ~clr_i[i]) | (irq_i[i] & ~irq_q[i]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q[i] <= 1'b0;
        irr_q[i] <= 1'b0;
      end else begin
        irq_q[i] <= irq_i[i];
        irr_q[i] <= nxt;
      end
    end
  end

  assign irr_o = irr_q;

  p_level_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irr_q & $past(level_i)) == ($past(irq_i) & $past(level_i))));
  p_edge_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i[0] && irq_q[0] && irq_i[0] && !irr_q[0]) |=> !irr_q[0]);
endmodule

// File: rtl/rpia_core.sv
module rpia_core
  import rpia_pkg::*;
#(
  parameter int unsigned N        = N_LINES,
  parameter int unsigned CASC_BIT = 2,
  localparam int unsigned W       = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] level_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_i,
  input  logic         auto_eoi_i,
  input  logic         special_mask_i,
  input  logic         nested_i,
  input  logic         cmd_valid_i,
  input  logic [2:0]   cmd_op_i,
  input  logic [W-1:0] cmd_line_i,
  input  logic         ack_i,
  output logic         int_o,
  output logic [W-1:0] ack_line_o,
  output logic [N-1:0] irr_o,
  output logic [N-1:0] isr_o,
  output logic [W-1:0] base_o
);
  logic [N-1:0] irr, imr_q, isr_q, isr_n, cur_vec, ack_oh, req_clr;
  logic [W-1:0] base_q, base_n, pend_line, cur_line, eoi_line;
  logic [W:0]   pend_slot, cur_slot, eoi_slot;
  logic         rot_q, rot_n, ack_fire, cmd_fire;
  rpia_op_e     op;

  rpia_req #(.N(N)) u_req (
    .clk_i, .rst_ni, .irq_i, .level_i,
    .clr_i (req_clr),
    .irr_o (irr)
  );

  always_comb begin
    cur_vec = isr_q;
    if (special_mask_i) cur_vec = cur_vec & ~imr_q;
    if (nested_i)       cur_vec[CASC_BIT] = 1'b0;
  end

  rpia_prio #(.N(N)) u_pend (.vec_i(irr & ~imr_q), .base_i(base_q), .slot_o(pend_slot), .line_o(pend_line));
  rpia_prio #(.N(N)) u_cur  (.vec_i(cur_vec),      .base_i(base_q), .slot_o(cur_slot),  .line_o(cur_line));
  rpia_prio #(.N(N)) u_eoi  (.vec_i(isr_q),        .base_i(base_q), .slot_o(eoi_slot),  .line_o(eoi_line));

  assign int_o      = pend_slot < cur_slot;
  assign ack_line_o = int_o ? pend_line : W'(N - 1);
  assign ack_fire   = ack_i & int_o;
  assign cmd_fire   = cmd_valid_i & ~ack_i;
  assign ack_oh     = N'(1) << pend_line;
  assign req_clr    = ack_fire ? (ack_oh & ~level_i) : '0;
  assign op         = rpia_op_e'(cmd_op_i);

  always_comb begin
    isr_n  = isr_q;
    base_n = base_q;
    rot_n  = rot_q;
    if (ack_fire) begin
      if (!auto_eoi_i)  isr_n  = isr_q | ack_oh;
      else if (rot_q)   base_n = pend_line + 1'b1;
    end else if (cmd_fire) begin
      unique case (op)
        OP_ROT_AEOI_CLR: rot_n = 1'b0;
        OP_ROT_AEOI_SET: rot_n = 1'b1;
        OP_NS_EOI, OP_NS_EOI_ROT: begin
          if (eoi_slot != (W+1)'(N)) begin
            isr_n[eoi_line] = 1'b0;
            if (op == OP_NS_EOI_ROT) base_n = eoi_line + 1'b1;
          end
        end
        OP_SP_EOI:     isr_n[cmd_line_i] = 1'b0;
        OP_SET_BASE:   base_n = cmd_line_i + 1'b1;
        OP_SP_EOI_ROT: begin
          isr_n[cmd_line_i] = 1'b0;
          base_n = cmd_line_i + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q  <= '0;
      isr_q  <= '0;
      base_q <= '0;
      rot_q  <= 1'b0;
    end else begin
      if (mask_we_i) imr_q <= mask_i;
      isr_q  <= isr_n;
      base_q <= base_n;
      rot_q  <= rot_n;
    end
  end

  assign irr_o  = irr;
  assign isr_o  = isr_q;
  assign base_o = base_q;

  p_int_needs_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~imr_q) != '0));
  p_ack_sets_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !auto_eoi_i) |=> ((isr_q & $past(ack_oh)) != '0));
  p_aeoi_no_isr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && auto_eoi_i) |=> $stable(isr_q));
  p_empty_eoi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && (cmd_op_i == 3'd1 || cmd_op_i == 3'd5) && isr_q == '0) |=> ($stable(isr_q) && $stable(base_q)));
  p_ns_eoi_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && cmd_op_i == 3'd1 && isr_q != '0) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
  p_ack_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && cmd_valid_i && !int_o) |=> ($stable(isr_q) && $stable(base_q)));
endmodule

// File: tb/tb_rpia_core.sv
module tb_rpia_core;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] irq_i = '0, level_i = '0, mask_i = '0;
  logic       mask_we_i = 0, auto_eoi_i = 0, special_mask_i = 0, nested_i = 0;
  logic       cmd_valid_i = 0, ack_i = 0;
  logic [2:0] cmd_op_i = '0, cmd_line_i = '0;
  logic       int_o;
  logic [2:0] ack_line_o, base_o;
  logic [7:0] irr_o, isr_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  rpia_core dut (.*);

  // {irq, mask, expected int, expected line}
  localparam logic [19:0] VEC [0:5] = '{
    {8'h00, 8'h00, 1'b0, 3'd7},
    {8'h28, 8'h00, 1'b1, 3'd3},
    {8'h28, 8'h08, 1'b1, 3'd5},
    {8'hFF, 8'hFF, 1'b0, 3'd7},
    {8'h80, 8'h7F, 1'b1, 3'd7},
    {8'h81, 8'h00, 1'b1, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic do_reset();
    irq_i = '0; mask_we_i = 0; mask_i = '0; auto_eoi_i = 0; special_mask_i = 0;
    nested_i = 0; cmd_valid_i = 0; ack_i = 0;
    rst_ni = 0;
    tick();
    rst_ni = 1;
    tick();
  endtask

  task automatic cmd(input logic [2:0] o, input logic [2:0] l);
    cmd_valid_i = 1; cmd_op_i = o; cmd_line_i = l;
    tick();
    cmd_valid_i = 0;
  endtask

  task automatic ack();
    ack_i = 1;
    tick();
    ack_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #100us;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    level_i = 8'hFF;
    do_reset();
    chk("R12 int", int_o, 0);
    chk("R12 irr", irr_o, 0);
    chk("R12 isr", isr_o, 0);
    chk("R12 base", base_o, 0);

    // resolver table, R1 R2 R12 mask load
    for (int i = 0; i < 6; i++) begin
      irq_i = VEC[i][19:12]; mask_i = VEC[i][11:4]; mask_we_i = 1;
      tick();
      mask_we_i = 0;
      chk($sformatf("R2 int vec%0d", i), int_o, VEC[i][3]);
      chk($sformatf("R1 line vec%0d", i), ack_line_o, VEC[i][2:0]);
    end

    // edge capture, acknowledge, strict comparison
    level_i = 8'h00;
    do_reset();
    irq_i = 8'h10; tick();
    chk("R5 edge set", irr_o, 8'h10);
    ack();
    chk("R6 isr set", isr_o, 8'h10);
    chk("R6 edge irr clr", irr_o, 8'h00);
    tick();
    chk("R5 held high no reset", irr_o, 8'h00);
    irq_i = 8'h50; tick();
    chk("R2 lower prio no int", int_o, 0);
    irq_i = 8'h40; tick();
    irq_i = 8'h50; tick();
    chk("R2 equal prio no int", int_o, 0);
    irq_i = 8'h52; tick();
    chk("R2 higher prio int", int_o, 1);
    chk("R1 winner line1", ack_line_o, 1);
    cmd(3'd1, 3'd0);
    chk("R8 ns eoi", isr_o, 8'h00);

    // rotation by command
    level_i = 8'hFF;
    do_reset();
    irq_i = 8'h03; tick();
    chk("R1 base0 line0", ack_line_o, 0);
    cmd(3'd6, 3'd0);
    chk("R9 set base", base_o, 1);
    chk("R1 rotated winner", ack_line_o, 1);
    cmd(3'd6, 3'd7);
    chk("R9 base wrap", base_o, 0);

    // level ack, rotating nonspecific eoi
    do_reset();
    irq_i = 8'h01; tick();
    ack();
    chk("R6 isr level", isr_o, 8'h01);
    chk("R6 level irr kept", irr_o, 8'h01);
    chk("R2 in service blocks", int_o, 0);
    cmd(3'd5, 3'd0);
    chk("R8 rot eoi isr", isr_o, 8'h00);
    chk("R8 rot eoi base", base_o, 1);
    chk("R1 lowest slot still wins", ack_line_o, 0);

    // special mask, specific eoi
    do_reset();
    irq_i = 8'h0C; tick();
    ack();
    mask_i = 8'h04; mask_we_i = 1; tick(); mask_we_i = 0;
    chk("R2 masked pend blocked", int_o, 0);
    special_mask_i = 1; #1;
    chk("R3 special mask int", int_o, 1);
    chk("R3 special mask line", ack_line_o, 3);
    ack();
    chk("R3 two in service", isr_o, 8'h0C);
    cmd(3'd3, 3'd3);
    chk("R9 specific eoi", isr_o, 8'h04);
    cmd(3'd7, 3'd2);
    chk("R9 specific rot isr", isr_o, 8'h00);
    chk("R9 specific rot base", base_o, 3);

    // cascade exclusion
    do_reset();
    irq_i = 8'h04; tick();
    ack();
    chk("R4 pre int", int_o, 0);
    nested_i = 1; #1;
    chk("R4 nested int", int_o, 1);
    chk("R4 nested line", ack_line_o, 2);

    // auto end of service
    do_reset();
    auto_eoi_i = 1;
    cmd(3'd4, 3'd0);
    irq_i = 8'h20; tick();
    ack();
    chk("R7 no isr", isr_o, 8'h00);
    chk("R7 rot base", base_o, 6);
    cmd(3'd6, 3'd0);
    cmd(3'd0, 3'd0);
    ack();
    chk("R10 rot cleared base", base_o, 1);
    chk("R7 still no isr", isr_o, 8'h00);

    // empty eoi and nop
    do_reset();
    cmd(3'd1, 3'd0);
    chk("R8 empty ns isr", isr_o, 0);
    cmd(3'd5, 3'd0);
    chk("R8 empty rot base", base_o, 0);
    irq_i = 8'h08; tick();
    ack();
    cmd(3'd2, 3'd3);
    chk("R10 nop isr", isr_o, 8'h08);
    chk("R10 nop base", base_o, 0);

    // ack wins over command
    do_reset();
    irq_i = 8'h02; tick();
    ack_i = 1; cmd_valid_i = 1; cmd_op_i = 3'd6; cmd_line_i = 3'd3;
    tick();
    ack_i = 0; cmd_valid_i = 0;
    chk("R11 isr", isr_o, 8'h02);
    chk("R11 base", base_o, 0);

    // acknowledge with nothing to give
    do_reset();
    chk("R6 idle line", ack_line_o, 7);
    ack();
    chk("R6 spurious ack isr", isr_o, 0);
    chk("R6 spurious ack base", base_o, 0);

    finish_run();
  end
endmodule